// File: doc/BRIEF.md
# Dual Temperature Sensor Serial Bridge

This block sits on a host register bus and stands in for a pair of three-wire digital temperature sensors, one at the chassis air inlet and one at the outlet. Firmware drives the pair one bit per access. It writes clock-level and reset codes to a control register. It shifts an eight-bit command, least significant bit first, through a data-write register. It then pulls the answer back one bit per read from a data-read register. Each bit lane of a read result belongs to a different sensor, so both sensors are read in the same sequence of accesses.

Inside, each channel holds a nine-bit temperature value in half-degree units and an eight-bit configuration value. Both can be preloaded through a side port. A shared engine keeps the partly built command, the command bit count, a data word for bits written after the command, and a bit position that is shared by data writes and reads. A read when no read command is latched returns zero and sets a sticky flag.

Top module: `ts_bridge`

## Requirements
- R1: A read of the data-read register (address 2) returns in bit i the current bit of channel i (channel 0 inlet, channel 1 outlet). All higher bits are zero. Any other read, or a read in a cycle that also writes, returns zero.
- R2: After reset each temperature register holds 44 (22 degrees in half-degree units) and each configuration register holds 0x02. The clock-low flag, the command, the counters, the data word and the unknown flag are all clear.
- R3: Writing 0xA5 to the control register (address 0) clears the command, the command bit count, the data word and the bit position.
- R4: Writing 0x3C to the control register sets the clock-low flag, and writing 0xC3 clears it. Other control values have no effect. While the flag is clear, every write to the data-write register (address 1) other than 0xE7 is ignored.
- R5: Writing 0xE7 to the data-write register sets the bit position to zero and changes nothing else, whatever the flag.
- R6: With the flag set, the first eight data writes build the command least significant bit first. A value of 0x01 sets the bit at the current count and any other value leaves it zero.
- R7: When the eighth command bit arrives, command 0xEE performs the full clear of R3. Commands 0xAA (read temperature) and 0xAC (read configuration) stay latched.
- R8: With 0xAA latched, each read returns bit `position` of each temperature register (zero for positions of 9 or more). The position then increments, saturating at 15. When the incremented position is 9 or more, the full clear of R3 follows.
- R9: With 0xAC latched, reads behave as in R8 on the configuration registers, with a limit of 8.
- R10: With the flag set and the command complete, each data write sets bit `position` of the nine-bit data word if the value is 0x01 and the position is below 9. It then increments the position, saturating at 15.
- R11: A read of address 2 with no read command latched returns zero and sets the unknown-command flag. Only reset clears that flag.
- R12: A preload strobe writes the temperature and configuration of the selected channel, and the new values are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register select: 0 control, 1 data write, 2 data read |
| host_wdata | input | 8 | Host write value |
| host_rdata | output | 8 | Read value (combinational, same cycle as strobe) |
| ld_en | input | 1 | Preload strobe |
| ld_chan | input | 1 | Preload channel |
| ld_temp | input | 9 | Preload temperature |
| ld_cfg | input | 8 | Preload configuration |
| host_word | output | 9 | Data word collected after the command |
| unk_cmd | output | 1 | Sticky unknown-command read flag |

## Verification
The hardest state to reach is a read command that is fully latched and then read through its last bit to the automatic clear. Getting there takes a control write that lowers the clock, eight exactly ordered data writes, and then nine or eight reads with no stray reset or enable-read code in between. Single random accesses almost never line all that up. The stimulus therefore mixes random single accesses with random bursts that each send a whole command, picked from the two read commands, start-convert and a random byte, with the clock flag sometimes left high. Reads and enable-read codes then land at every position within a latched read.

// File: rtl/ts_bridge_pkg.sv
package ts_bridge_pkg;

    localparam int unsigned DEF_CH     = 2;
    localparam int unsigned DEF_CMD_W  = 8;
    localparam int unsigned DEF_TEMP_W = 9;
    localparam int unsigned DEF_CFG_W  = 8;
    localparam int unsigned DEF_WORD_W = 9;
    localparam int unsigned DEF_BUS_W  = 8;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DWR  = 2'd1,
        REG_DRD  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TEMP = 2'd1,
        SRC_CFG  = 2'd2
    } rd_src_e;

    localparam logic [7:0] CTL_RESET  = 8'hA5;
    localparam logic [7:0] CTL_CLK_LO = 8'h3C;
    localparam logic [7:0] CTL_CLK_HI = 8'hC3;
    localparam logic [7:0] DW_HIGH    = 8'h01;
    localparam logic [7:0] DW_ENRD    = 8'hE7;
    localparam logic [7:0] CMD_CONV   = 8'hEE;
    localparam logic [7:0] CMD_RDTEMP = 8'hAA;
    localparam logic [7:0] CMD_RDCFG  = 8'hAC;

endpackage

// File: rtl/ts_sensor_bank.sv
module ts_sensor_bank
    import ts_bridge_pkg::*;
#(
    parameter int unsigned NUM_CH     = DEF_CH,
    parameter int unsigned TEMP_W     = DEF_TEMP_W,
    parameter int unsigned CFG_W      = DEF_CFG_W,
    parameter int unsigned TEMP_RESET = 44,
    parameter int unsigned CFG_RESET  = 2,
    localparam int unsigned CH_IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             ld_en,
    input  logic [CH_IDX_W-1:0]              ld_chan,
    input  logic [TEMP_W-1:0]                ld_temp,
    input  logic [CFG_W-1:0]                 ld_cfg,
    output logic [NUM_CH-1:0][TEMP_W-1:0]    temp_q,
    output logic [NUM_CH-1:0][CFG_W-1:0]     cfg_q
);

    typedef struct packed {
        logic [TEMP_W-1:0] temp;
        logic [CFG_W-1:0]  cfg;
    } chan_t;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        chan_t ch_d, ch_q;

        always_comb begin
            ch_d = ch_q;
            if (ld_en && (ld_chan == CH_IDX_W'(g))) begin
                ch_d.temp = ld_temp;
                ch_d.cfg  = ld_cfg;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ch_q.temp <= TEMP_W'(TEMP_RESET);
                ch_q.cfg  <= CFG_W'(CFG_RESET);
            end else begin
                ch_q <= ch_d;
            end
        end

        assign temp_q[g] = ch_q.temp;
        assign cfg_q[g]  = ch_q.cfg;
    end

endmodule

// File: rtl/ts_lane_mux.sv
module ts_lane_mux
    import ts_bridge_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_CH,
    parameter int unsigned TEMP_W = DEF_TEMP_W,
    parameter int unsigned CFG_W  = DEF_CFG_W,
    parameter int unsigned POS_W  = 4
) (
    input  rd_src_e                          src,
    input  logic [POS_W-1:0]                 pos,
    input  logic [NUM_CH-1:0][TEMP_W-1:0]    temp_q,
    input  logic [NUM_CH-1:0][CFG_W-1:0]     cfg_q,
    output logic [NUM_CH-1:0]                lanes
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        logic [TEMP_W-1:0] temp_sh;
        logic [CFG_W-1:0]  cfg_sh;

        always_comb begin
            temp_sh = temp_q[g] >> pos;
            cfg_sh  = cfg_q[g] >> pos;
            unique case (src)
                SRC_TEMP: lanes[g] = temp_sh[0];
                SRC_CFG:  lanes[g] = cfg_sh[0];
                default:  lanes[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ts_bridge_engine.sv
module ts_bridge_engine
    import ts_bridge_pkg::*;
#(
    parameter int unsigned CMD_W  = DEF_CMD_W,
    parameter int unsigned TEMP_W = DEF_TEMP_W,
    parameter int unsigned CFG_W  = DEF_CFG_W,
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned BUS_W  = DEF_BUS_W,
    parameter logic [CMD_W-1:0] C_CONV   = CMD_W'(CMD_CONV),
    parameter logic [CMD_W-1:0] C_RDTEMP = CMD_W'(CMD_RDTEMP),
    parameter logic [CMD_W-1:0] C_RDCFG  = CMD_W'(CMD_RDCFG),
    localparam int unsigned MAX_W = (TEMP_W > CFG_W) ?
                                    ((TEMP_W > WORD_W) ? TEMP_W : WORD_W) :
                                    ((CFG_W > WORD_W) ? CFG_W : WORD_W),
    localparam int unsigned POS_W = $clog2(MAX_W + 1),
    localparam int unsigned CP_W  = $clog2(CMD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_addr,
    input  logic [BUS_W-1:0]  host_wdata,
    output rd_src_e           rd_src,
    output logic [POS_W-1:0]  pos,
    output logic [WORD_W-1:0] host_word,
    output logic              unk_cmd,
    output logic              clk_low
);

    localparam logic [CP_W-1:0]  CMD_DONE = CP_W'(CMD_W);
    localparam logic [POS_W:0]   TEMP_LIM = (POS_W+1)'(TEMP_W);
    localparam logic [POS_W:0]   CFG_LIM  = (POS_W+1)'(CFG_W);
    localparam logic [POS_W-1:0] WORD_LIM = POS_W'(WORD_W);

    typedef struct packed {
        logic              clk_low;
        logic [CMD_W-1:0]  cmd;
        logic [CP_W-1:0]   cmd_pos;
        logic [WORD_W-1:0] word;
        logic [POS_W-1:0]  pos;
        logic              unk;
    } eng_t;

    eng_t st_d, st_q;

    logic             cmd_done;
    logic [POS_W:0]   pos_inc;
    logic [POS_W-1:0] pos_sat;
    logic [CP_W-1:0]  cpos_inc;
    rd_src_e          src_w;

    always_comb begin
        cmd_done = (st_q.cmd_pos == CMD_DONE);
        pos_inc  = {1'b0, st_q.pos} + 1'b1;
        pos_sat  = (&st_q.pos) ? st_q.pos : pos_inc[POS_W-1:0];
        cpos_inc = st_q.cmd_pos + 1'b1;

        if (cmd_done && st_q.cmd == C_RDTEMP)     src_w = SRC_TEMP;
        else if (cmd_done && st_q.cmd == C_RDCFG) src_w = SRC_CFG;
        else                                      src_w = SRC_NONE;

        st_d = st_q;

        if (host_wr) begin
            unique case (reg_sel_e'(host_addr))
                REG_CTRL: begin
                    if (host_wdata == BUS_W'(CTL_RESET)) begin
                        st_d.cmd     = '0;
                        st_d.cmd_pos = '0;
                        st_d.word    = '0;
                        st_d.pos     = '0;
                    end else if (host_wdata == BUS_W'(CTL_CLK_LO)) begin
                        st_d.clk_low = 1'b1;
                    end else if (host_wdata == BUS_W'(CTL_CLK_HI)) begin
                        st_d.clk_low = 1'b0;
                    end
                end
                REG_DWR: begin
                    if (host_wdata == BUS_W'(DW_ENRD)) begin
                        st_d.pos = '0;
                    end else if (st_q.clk_low) begin
                        if (!cmd_done) begin
                            if (host_wdata == BUS_W'(DW_HIGH))
                                st_d.cmd = st_q.cmd | (CMD_W'(1) << st_q.cmd_pos);
                            st_d.cmd_pos = cpos_inc;
                            if (cpos_inc == CMD_DONE && st_d.cmd == C_CONV) begin
                                st_d.cmd     = '0;
                                st_d.cmd_pos = '0;
                                st_d.word    = '0;
                                st_d.pos     = '0;
                            end
                        end else begin
                            if (host_wdata == BUS_W'(DW_HIGH) && st_q.pos < WORD_LIM)
                                st_d.word = st_q.word | (WORD_W'(1) << st_q.pos);
                            st_d.pos = pos_sat;
                        end
                    end
                end
                default: ;
            endcase
        end else if (host_rd && reg_sel_e'(host_addr) == REG_DRD) begin
            if (src_w == SRC_NONE) begin
                st_d.unk = 1'b1;
            end else begin
                st_d.pos = pos_sat;
                if ((src_w == SRC_TEMP && pos_inc >= TEMP_LIM) ||
                    (src_w == SRC_CFG  && pos_inc >= CFG_LIM)) begin
                    st_d.cmd     = '0;
                    st_d.cmd_pos = '0;
                    st_d.word    = '0;
                    st_d.pos     = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_src    = src_w;
    assign pos       = st_q.pos;
    assign host_word = st_q.word;
    assign unk_cmd   = st_q.unk;
    assign clk_low   = st_q.clk_low;

endmodule

// File: rtl/ts_bridge.sv
module ts_bridge
    import ts_bridge_pkg::*;
#(
    parameter int unsigned NUM_CH     = DEF_CH,
    parameter int unsigned CMD_W      = DEF_CMD_W,
    parameter int unsigned TEMP_W     = DEF_TEMP_W,
    parameter int unsigned CFG_W      = DEF_CFG_W,
    parameter int unsigned WORD_W     = DEF_WORD_W,
    parameter int unsigned BUS_W      = DEF_BUS_W,
    parameter int unsigned TEMP_RESET = 44,
    parameter int unsigned CFG_RESET  = 2,
    localparam int unsigned CH_IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned MAX_W = (TEMP_W > CFG_W) ?
                                    ((TEMP_W > WORD_W) ? TEMP_W : WORD_W) :
                                    ((CFG_W > WORD_W) ? CFG_W : WORD_W),
    localparam int unsigned POS_W = $clog2(MAX_W + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [1:0]          host_addr,
    input  logic [BUS_W-1:0]    host_wdata,
    output logic [BUS_W-1:0]    host_rdata,
    input  logic                ld_en,
    input  logic [CH_IDX_W-1:0] ld_chan,
    input  logic [TEMP_W-1:0]   ld_temp,
    input  logic [CFG_W-1:0]    ld_cfg,
    output logic [WORD_W-1:0]   host_word,
    output logic                unk_cmd
);

    logic [NUM_CH-1:0][TEMP_W-1:0] temp_q;
    logic [NUM_CH-1:0][CFG_W-1:0]  cfg_q;
    logic [NUM_CH-1:0]             lanes;
    logic [POS_W-1:0]              pos;
    rd_src_e                       rd_src;
    logic                          clk_low;

    ts_sensor_bank #(
        .NUM_CH(NUM_CH), .TEMP_W(TEMP_W), .CFG_W(CFG_W),
        .TEMP_RESET(TEMP_RESET), .CFG_RESET(CFG_RESET)
    ) u_bank (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_chan(ld_chan),
        .ld_temp(ld_temp), .ld_cfg(ld_cfg),
        .temp_q(temp_q), .cfg_q(cfg_q)
    );

    ts_bridge_engine #(
        .CMD_W(CMD_W), .TEMP_W(TEMP_W), .CFG_W(CFG_W),
        .WORD_W(WORD_W), .BUS_W(BUS_W)
    ) u_eng (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .rd_src(rd_src), .pos(pos), .host_word(host_word),
        .unk_cmd(unk_cmd), .clk_low(clk_low)
    );

    ts_lane_mux #(
        .NUM_CH(NUM_CH), .TEMP_W(TEMP_W), .CFG_W(CFG_W), .POS_W(POS_W)
    ) u_mux (
        .src(rd_src), .pos(pos), .temp_q(temp_q), .cfg_q(cfg_q), .lanes(lanes)
    );

    always_comb begin
        host_rdata = '0;
        if (host_rd && !host_wr && reg_sel_e'(host_addr) == REG_DRD)
            host_rdata[NUM_CH-1:0] = lanes;
    end

endmodule

// File: rtl/ts_bridge_chk.sv
module ts_bridge_chk
    import ts_bridge_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_CH,
    parameter int unsigned BUS_W  = DEF_BUS_W,
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic              host_rd,
    input logic [1:0]        host_addr,
    input logic [BUS_W-1:0]  host_wdata,
    input logic [BUS_W-1:0]  host_rdata,
    input logic [WORD_W-1:0] host_word,
    input logic              unk_cmd,
    input logic              clk_low,
    input logic [1:0]        rd_src
);

    logic wr_ctrl, wr_dwr, rd_drd;
    assign wr_ctrl = host_wr && host_addr == 2'(REG_CTRL);
    assign wr_dwr  = host_wr && host_addr == 2'(REG_DWR);
    assign rd_drd  = host_rd && !host_wr && host_addr == 2'(REG_DRD);

    // R1: lanes above the channel count never carry data
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (host_rdata >> NUM_CH) == '0);

    // R1: no read strobe means a zero result
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !host_rd |-> host_rdata == '0);

    // R3: reset code empties the word and drops any latched read
    a_r3_reset_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && host_wdata == BUS_W'(CTL_RESET))
        |=> (host_word == '0 && rd_src == 2'(SRC_NONE)));

    // R4: clock-low code raises the flag, clock-high code drops it
    a_r4_clk_low_set: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && host_wdata == BUS_W'(CTL_CLK_LO)) |=> clk_low);
    a_r4_clk_high_clr: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && host_wdata == BUS_W'(CTL_CLK_HI)) |=> !clk_low);

    // R4: data writes are inert while the clock level is high
    a_r4_ignored_high: assert property (@(posedge clk) disable iff (rst)
        (wr_dwr && !clk_low && host_wdata != BUS_W'(DW_ENRD))
        |=> ($stable(host_word) && $stable(rd_src)));

    // R5: enable-read touches neither word nor latched command
    a_r5_enrd_only_pos: assert property (@(posedge clk) disable iff (rst)
        (wr_dwr && host_wdata == BUS_W'(DW_ENRD))
        |=> ($stable(host_word) && $stable(rd_src)));

    // R11: read without a latched command gives zero and raises the flag
    a_r11_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_drd && rd_src == 2'(SRC_NONE)) |-> host_rdata == '0);
    a_r11_invalid_flag: assert property (@(posedge clk) disable iff (rst)
        (rd_drd && rd_src == 2'(SRC_NONE)) |=> unk_cmd);

    // R11: flag is sticky
    a_r11_unk_sticky: assert property (@(posedge clk) disable iff (rst)
        unk_cmd |=> unk_cmd);

endmodule

bind ts_bridge ts_bridge_chk #(
    .NUM_CH(NUM_CH), .BUS_W(BUS_W), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_word(host_word), .unk_cmd(unk_cmd), .clk_low(clk_low),
    .rd_src(rd_src)
);

// File: tb/ts_bridge_tb.sv
module ts_bridge_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       ld_en = 1'b0;
    logic       ld_chan = 1'b0;
    logic [8:0] ld_temp = 9'd0;
    logic [7:0] ld_cfg = 8'd0;
    logic [8:0] host_word;
    logic       unk_cmd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side model, written from the requirements
    int m_cmd, m_cpos, m_word, m_pos;
    bit m_clk, m_unk;
    int m_temp[2];
    int m_cfg[2];

    always #4 clk = ~clk;

    ts_bridge u_dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ld_en(ld_en), .ld_chan(ld_chan), .ld_temp(ld_temp), .ld_cfg(ld_cfg),
        .host_word(host_word), .unk_cmd(unk_cmd)
    );

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    function automatic void m_clear();
        m_cmd = 0; m_cpos = 0; m_word = 0; m_pos = 0;
    endfunction

    function automatic int m_sat(int p);
        return (p >= 15) ? 15 : p + 1;
    endfunction

    // expected lanes for a read with a latched command (R8, R9)
    function automatic int exp_lanes(bit is_temp);
        int r = 0;
        for (int i = 0; i < 2; i++)
            r |= (((is_temp ? m_temp[i] : m_cfg[i]) >> m_pos) & 1) << i;
        return r;
    endfunction

    task automatic state_chk(string tag);
        chk({tag, " word"}, int'(host_word), m_word);
        chk({"R11 ", tag, " unk"}, int'(unk_cmd), int'(m_unk));
    endtask

    task automatic ctrl_wr(logic [7:0] v);
        @(negedge clk);
        state_chk("R3");
        host_wr = 1; host_addr = 2'd0; host_wdata = v;
        if (v == 8'hA5) m_clear();
        else if (v == 8'h3C) m_clk = 1;
        else if (v == 8'hC3) m_clk = 0;
        @(posedge clk); #1 host_wr = 0;
    endtask

    task automatic dw_wr(logic [7:0] v);
        @(negedge clk);
        state_chk("R10");
        host_wr = 1; host_addr = 2'd1; host_wdata = v;
        if (v == 8'hE7) m_pos = 0;
        else if (m_clk) begin
            if (m_cpos < 8) begin
                if (v == 8'h01) m_cmd |= 1 << m_cpos;
                m_cpos++;
                if (m_cpos == 8 && m_cmd == 8'hEE) m_clear();
            end else begin
                if (m_pos < 9 && v == 8'h01) m_word |= 1 << m_pos;
                m_pos = m_sat(m_pos);
            end
        end
        @(posedge clk); #1 host_wr = 0;
    endtask

    task automatic rd_any(logic [1:0] a);
        int e;
        bit vt, vc;
        @(negedge clk);
        state_chk("R6");
        host_rd = 1; host_addr = a;
        #1;
        vt = (m_cpos == 8 && m_cmd == 8'hAA);
        vc = (m_cpos == 8 && m_cmd == 8'hAC);
        if (a != 2'd2) begin
            chk("R1 other addr read", int'(host_rdata), 0);
        end else if (!vt && !vc) begin
            chk("R11 invalid read", int'(host_rdata), 0);
            m_unk = 1;
        end else begin
            e = exp_lanes(vt);
            chk(vt ? "R8 temp lanes" : "R9 cfg lanes", int'(host_rdata), e);
            m_pos = m_sat(m_pos);
            if (m_pos >= (vt ? 9 : 8)) m_clear();
        end
        @(posedge clk); #1 host_rd = 0;
    endtask

    task automatic preload(bit ch, logic [8:0] t, logic [7:0] c);
        @(negedge clk);
        ld_en = 1; ld_chan = ch; ld_temp = t; ld_cfg = c;
        m_temp[ch] = int'(t); m_cfg[ch] = int'(c);
        @(posedge clk); #1 ld_en = 0;
    endtask

    task automatic send_cmd(logic [7:0] c);
        for (int b = 0; b < 8; b++) dw_wr(c[b] ? 8'h01 : 8'h00);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED1234);
        m_clear(); m_clk = 0; m_unk = 0;
        m_temp[0] = 44; m_temp[1] = 44; m_cfg[0] = 2; m_cfg[1] = 2;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R2: reset contents read back through a full temperature read
        @(negedge clk);
        chk("R2 word after reset", int'(host_word), 0);
        chk("R2 unk after reset", int'(unk_cmd), 0);
        ctrl_wr(8'h3C);
        send_cmd(8'hAA);
        for (int k = 0; k < 9; k++) rd_any(2'd2);
        rd_any(2'd2);                    // R8: auto-clear -> now invalid, R11
        chk("R8 word after auto clear", int'(host_word), 0);

        // R4: clock high makes data writes inert
        ctrl_wr(8'hC3);
        send_cmd(8'hAC);
        rd_any(2'd2);
        // R9 config read with R5 enable-read in the middle
        ctrl_wr(8'h3C);
        send_cmd(8'hAC);
        rd_any(2'd2); rd_any(2'd2); rd_any(2'd2);
        dw_wr(8'hE7);
        for (int k = 0; k < 8; k++) rd_any(2'd2);
        // R7: start-convert clears, R10 data word after unknown command
        send_cmd(8'hEE);
        rd_any(2'd2);
        send_cmd(8'h55);
        dw_wr(8'h01); dw_wr(8'h00); dw_wr(8'h01);
        ctrl_wr(8'h99);                  // R4: non-code control has no effect
        dw_wr(8'h01);
        for (int k = 0; k < 14; k++) dw_wr(8'h01);
        ctrl_wr(8'hA5);                  // R3
        // R12: preload then read both channels
        preload(1'b0, 9'h1A5, 8'h5A);
        preload(1'b1, 9'h0F3, 8'hC1);
        send_cmd(8'hAA);
        for (int k = 0; k < 9; k++) rd_any(2'd2);
        send_cmd(8'hAC);
        for (int k = 0; k < 8; k++) rd_any(2'd2);

        // random mix with command bursts
        for (int n = 0; n < 3000; n++) begin
            int sel = $urandom_range(0, 99);
            if (sel < 8) begin
                int c = $urandom_range(0, 4);
                ctrl_wr(c == 0 ? 8'hA5 : c == 1 ? 8'hC3 : c == 4 ? 8'($urandom) : 8'h3C);
            end else if (sel < 30) begin
                int c = $urandom_range(0, 5);
                dw_wr(c < 2 ? 8'h01 : c < 4 ? 8'h00 : c == 4 ? 8'hE7 : 8'($urandom));
            end else if (sel < 65) begin
                rd_any($urandom_range(0, 9) == 0 ? 2'($urandom) : 2'd2);
            end else if (sel < 70) begin
                preload(1'($urandom), 9'($urandom), 8'($urandom));
            end else if (sel < 80) begin
                int c = $urandom_range(0, 4);
                if ($urandom_range(0, 3) != 0) ctrl_wr(8'h3C);
                send_cmd(c < 2 ? 8'hAA : c == 2 ? 8'hAC : c == 3 ? 8'hEE : 8'($urandom));
            end else begin
                rd_any(2'd2);
            end
        end

        @(negedge clk);
        state_chk("R10 final");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule